// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This block is a 16-bit timer/counter for a microcontroller-style peripheral set. Its count register advances either once per machine-cycle tick (timer function) or on each falling edge of an external count pin (counter function). Software selects one of three modes. Capture mode copies the running count into a holding register pair when a trigger pin falls. Auto-reload mode reloads the count from that register pair on overflow or on a trigger edge. Baud mode turns every overflow into a clock pulse for a serial port.

Software uses a byte-wide register port with five locations: control, count low, count high, reload/capture low and reload/capture high. Two status flags live in the top bits of the control byte. They are set by hardware and cleared by software. An interrupt request is formed from the two flags and gated by an enable input.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register location reads 0x00. The flags, `irq` and `baud_tick` are all 0.
- R2: Control bit 0 (run) enables counting. With run=1 and control bit 1 (source select) = 0, the count rises by one on each cycle in which `tick` is high. With run=0 the count holds whatever `tick` and the pins do.
- R3: With control bit 1 = 1, the count rises by one per falling edge of `cnt_pin`, and `tick` is ignored. Each pin passes through a two-flop synchronizer. A fall is seen when one sample is 1 and the next is 0. The increment lands on the third clock edge after the pin falls.
- R4: Auto-reload mode is run=1, control bit 2 (capture select) = 0, and serial bits 4 and 5 both 0. In this mode, an advance from 0xFFFF loads the reload pair into the count and sets the overflow flag (control bit 7).
- R5: Capture mode is run=1, bit 2 = 1, and bits 4 and 5 both 0. In this mode, an advance from 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R6: In capture mode with control bit 3 (trigger enable) = 1, a falling edge on `trig_pin` copies the count into the capture pair and sets the event flag (control bit 6). The count is left unchanged. With bit 3 = 0 the edge has no effect.
- R7: In auto-reload mode with bit 3 = 1, a falling edge on `trig_pin` loads the count from the reload pair and sets the event flag.
- R8: If either serial bit (4 receive, 5 transmit) is 1 while running, the block is in baud mode. Every overflow reloads, whatever bit 2 holds. Every overflow produces a one-cycle `baud_tick` pulse one edge later. The overflow flag is never set, and `trig_pin` neither captures, reloads nor sets the event flag.
- R9: `irq` is a register that follows `irq_en` AND (overflow flag OR event flag), one cycle behind its inputs.
- R10: A software write to a count byte in the same cycle as an advance takes priority over the advance. Writing the control byte writes both flags, so writing 0 clears them. A hardware set in the same cycle wins over the write.
- R11: `rd_data` is registered. It shows the location addressed by `rd_addr` one clock later. Address 0 is control, 1 is count low, 2 is count high, 3 is reload/capture low and 4 is reload/capture high. Other addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable for timer function |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write location |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read location |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | Overflow pulse for serial clocking |

## Verification
Results arrive at different cycles, and each check is placed at the cycle its result is due. A write or a tick takes effect at the next edge. A pin fall changes state on the third edge. `baud_tick` and `irq` appear one edge after the event that causes them, and read data one edge after the address is presented. The bench drives on falling clock edges, holds `tick` low while it reads, and waits past these latencies before sampling. Random baud-mode runs compare the final count and the number of pulses against a closed-form model of the reload period.

// File: rtl/cap_reload_timer_pkg.sv
package cap_reload_timer_pkg;
  typedef enum logic [1:0] {
    TM_OFF     = 2'd0,
    TM_RELOAD  = 2'd1,
    TM_CAPTURE = 2'd2,
    TM_BAUD    = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] LOC_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] LOC_CNTL  = 3'd1;
  localparam logic [ADDR_W-1:0] LOC_CNTH  = 3'd2;
  localparam logic [ADDR_W-1:0] LOC_RLDL  = 3'd3;
  localparam logic [ADDR_W-1:0] LOC_RLDH  = 3'd4;

  localparam int B_RUN = 0, B_SRC = 1, B_CAP = 2, B_TEN = 3, B_RXC = 4, B_TXC = 5;

  function automatic tmr_mode_e decode_mode(input logic run, input logic ser,
                                            input logic cap);
    if (!run)     return TM_OFF;
    else if (ser) return TM_BAUD;
    else if (cap) return TM_CAPTURE;
    else          return TM_RELOAD;
  endfunction
endpackage

// File: rtl/pin_fall_det.sv
module pin_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk)
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[STAGES-1];

  assign fall = prev_q & ~sync_q[STAGES-1];

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R3
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import cap_reload_timer_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_mode_e     mode,
  input  logic          inc,
  input  logic          trig_fire,
  input  logic          wr_cnt_lo,
  input  logic          wr_cnt_hi,
  input  logic          wr_rld_lo,
  input  logic          wr_rld_hi,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] rld,
  output logic          ovf_evt,
  output logic          ext_evt
);
  logic adv, trig_rld, trig_cap, reload_on_ovf;

  assign adv           = inc && (mode != TM_OFF);
  assign ovf_evt       = adv && (count == {CW{1'b1}});
  assign reload_on_ovf = (mode == TM_RELOAD) || (mode == TM_BAUD);
  assign trig_rld      = trig_fire && (mode == TM_RELOAD);
  assign trig_cap      = trig_fire && (mode == TM_CAPTURE);
  assign ext_evt       = trig_rld || trig_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      if (adv) count <= (ovf_evt && reload_on_ovf) ? rld : count + 1'b1;
      if (trig_rld) count <= rld;
      if (wr_cnt_lo) count[DW-1:0]  <= wr_data;
      if (wr_cnt_hi) count[CW-1:DW] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rld <= '0;
    end else begin
      if (trig_cap) rld <= count;
      if (wr_rld_lo) rld[DW-1:0]  <= wr_data;
      if (wr_rld_hi) rld[CW-1:DW] <= wr_data;
    end
  end

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_OFF && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(count)); // R2
  AST_RELOAD_AFTER_OVF: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && mode == TM_RELOAD && !wr_cnt_lo && !wr_cnt_hi)
      |=> count == $past(rld)); // R4
  AST_CAP_ONLY_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
    (!trig_cap && !wr_rld_lo && !wr_rld_hi) |=> $stable(rld)); // R6
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import cap_reload_timer_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              irq,
  output logic              baud_tick
);
  localparam int CW = 2 * DW;

  logic [5:0]    ctrl_q;
  logic          ovf_q, evt_q;
  logic          cnt_fall, trig_fall;
  logic          ser_en, inc, trig_fire, wr_ctrl;
  logic          ovf_evt, ext_evt;
  logic [CW-1:0] count, rld;
  tmr_mode_e     mode;

  pin_fall_det #(.STAGES(SYNC_STAGES)) u_cnt_det (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall));
  pin_fall_det #(.STAGES(SYNC_STAGES)) u_trig_det (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall));

  assign ser_en    = ctrl_q[B_RXC] | ctrl_q[B_TXC];
  assign mode      = decode_mode(ctrl_q[B_RUN], ser_en, ctrl_q[B_CAP]);
  assign inc       = ctrl_q[B_SRC] ? cnt_fall : tick;
  assign trig_fire = trig_fall & ctrl_q[B_TEN];
  assign wr_ctrl   = wr_en && (wr_addr == LOC_CTRL);

  tmr_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .mode(mode), .inc(inc), .trig_fire(trig_fire),
    .wr_cnt_lo(wr_en && wr_addr == LOC_CNTL),
    .wr_cnt_hi(wr_en && wr_addr == LOC_CNTH),
    .wr_rld_lo(wr_en && wr_addr == LOC_RLDL),
    .wr_rld_hi(wr_en && wr_addr == LOC_RLDH),
    .wr_data(wr_data), .count(count), .rld(rld),
    .ovf_evt(ovf_evt), .ext_evt(ext_evt));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ovf_q     <= 1'b0;
      evt_q     <= 1'b0;
      baud_tick <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[5:0];
      ovf_q     <= (wr_ctrl ? wr_data[7] : ovf_q) | (ovf_evt && mode != TM_BAUD);
      evt_q     <= (wr_ctrl ? wr_data[6] : evt_q) | ext_evt;
      baud_tick <= ovf_evt && (mode == TM_BAUD);
      irq       <= irq_en && (ovf_q || evt_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        LOC_CTRL: rd_data <= {ovf_q, evt_q, ctrl_q};
        LOC_CNTL: rd_data <= count[DW-1:0];
        LOC_CNTH: rd_data <= count[CW-1:DW];
        LOC_RLDL: rd_data <= rld[DW-1:0];
        LOC_RLDH: rd_data <= rld[CW-1:DW];
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_BAUD_NO_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!ovf_q && ser_en && !wr_ctrl) |=> !ovf_q); // R8
  AST_BAUD_NO_EVT: assert property (@(posedge clk) disable iff (rst)
    (!evt_q && ser_en && !wr_ctrl) |=> !evt_q); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq); // R9
endmodule

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;
  logic clk = 1'b0, rst = 1'b1;
  logic tick = 0, cnt_pin = 1, trig_pin = 1, irq_en = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq, baud_tick;
  int errors = 0, checks = 0, bauds = 0;
  bit done = 0;

  cap_reload_timer uut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) if (!rst && baud_tick) bauds++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a_lo, lo); rd(a_lo + 3'd1, hi); v = {hi, lo};
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic pin_fall(input bit trig_sel);
    @(negedge clk);
    if (trig_sel) trig_pin = 0; else cnt_pin = 0;
    repeat (4) @(negedge clk);
    if (trig_sel) trig_pin = 1; else cnt_pin = 1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_count(int r, int n);
    return r + (n % (65536 - r));
  endfunction
  function automatic int exp_pulses(int r, int n);
    return n / (65536 - r);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk("R1 reg", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 baud", baud_tick, 0);

    // R2 timer function, then idle hold
    wr(3'd0, 8'h01);
    ticks(5);
    rd16(3'd1, w); chk("R2 ticks", w, 5);
    repeat (10) @(negedge clk);
    rd16(3'd1, w); chk("R2 no tick", w, 5);
    wr(3'd0, 8'h00);
    ticks(7);
    rd16(3'd1, w); chk("R2 run off", w, 5);

    // R3 counter function, tick ignored
    wr(3'd0, 8'h03);
    tick = 1;
    pin_fall(0); pin_fall(0); pin_fall(0);
    tick = 0;
    rd16(3'd1, w); chk("R3 pin edges", w, 8);

    // R4 auto-reload overflow
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    ticks(3);
    rd16(3'd1, w); chk("R4 reload", w, 16'h1235);
    rd(3'd0, v); chk("R4 ovf flag", v, 8'h81);

    // R9 irq gating
    chk("R9 irq off", irq, 0);
    irq_en = 1;
    repeat (2) @(negedge clk);
    chk("R9 irq on", irq, 1);
    wr(3'd0, 8'h01);
    repeat (2) @(negedge clk);
    chk("R9 irq cleared", irq, 0);
    irq_en = 0;

    // R5 capture-mode wrap
    wr(3'd0, 8'h05);
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    ticks(1);
    rd16(3'd1, w); chk("R5 wrap", w, 0);
    rd(3'd0, v); chk("R5 ovf flag", v, 8'h85);

    // R6 capture disabled, then enabled
    wr(3'd0, 8'h05);
    wr(3'd1, 8'hBC); wr(3'd2, 8'h0A);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    pin_fall(1);
    rd16(3'd3, w); chk("R6 no trig enable", w, 0);
    rd(3'd0, v); chk("R6 no evt", v, 8'h05);
    wr(3'd0, 8'h0D);
    pin_fall(1);
    rd16(3'd3, w); chk("R6 captured", w, 16'h0ABC);
    rd16(3'd1, w); chk("R6 count kept", w, 16'h0ABC);
    rd(3'd0, v); chk("R6 evt flag", v, 8'h4D);

    // R7 trigger reload
    wr(3'd0, 8'h09);
    wr(3'd3, 8'h02); wr(3'd4, 8'h01);
    wr(3'd1, 8'h55); wr(3'd2, 8'h55);
    pin_fall(1);
    rd16(3'd1, w); chk("R7 trig reload", w, 16'h0102);
    rd(3'd0, v); chk("R7 evt flag", v, 8'h49);

    // R8 baud mode overrides capture select and trigger
    wr(3'd0, 8'h1D);
    wr(3'd3, 8'h00); wr(3'd4, 8'hF0);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    bauds = 0;
    ticks(2);
    repeat (2) @(negedge clk);
    chk("R8 one pulse", bauds, 1);
    rd16(3'd1, w); chk("R8 forced reload", w, 16'hF000);
    pin_fall(1);
    rd16(3'd1, w); chk("R8 trig ignored", w, 16'hF000);
    rd16(3'd3, w); chk("R8 no capture", w, 16'hF000);
    rd(3'd0, v); chk("R8 no flags", v, 8'h1D);

    // R10 write beats increment
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h10); wr(3'd2, 8'h00);
    @(negedge clk); wr_en = 1; wr_addr = 3'd1; wr_data = 8'h77; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    rd16(3'd1, w); chk("R10 write priority", w, 16'h0077);

    // R11 unmapped address
    rd(3'd6, v); chk("R11 unmapped", v, 0);

    // R8 random baud runs
    for (int t = 0; t < 6; t++) begin
      int r, n;
      r = 16'hFF00 + ($urandom % 255);
      n = 50 + ($urandom % 500);
      wr(3'd0, 8'h21);
      wr(3'd3, r[7:0]); wr(3'd4, r[15:8]);
      wr(3'd1, r[7:0]); wr(3'd2, r[15:8]);
      bauds = 0;
      ticks(n);
      repeat (3) @(negedge clk);
      rd16(3'd1, w); chk("R8 random count", w, exp_count(r, n));
      chk("R8 random pulses", bauds, exp_pulses(r, n));
    end

    finish_run();
  end
endmodule